// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the stack and vector-table work that a small 16-bit processor performs when it takes an interrupt or exception, and the reverse work when a handler returns. At each instruction boundary it looks at the pending sources: a divide fault, a software interrupt with an 8-bit type, a breakpoint, an overflow check, a latched non-maskable edge, a maskable request and the single-step flag. It picks the most urgent one, saves the flags, code segment and instruction pointer on the stack, and loads the new code segment and instruction pointer from the vector table.

For a maskable request it first runs a two-pulse acknowledge handshake and takes the type byte from the acknowledge bus on the second pulse. A return command at a boundary pops the three saved words and hands them back. All memory traffic uses one word-wide request/ready port. The stack uses the stack pointer, zero-extended, as its byte address. The new register values are presented together, with a one-cycle completion pulse. Decoding and executing instructions is the job of the surrounding core.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is applied and just after it, flags_o, cs_o, ip_o and sp_o are 0, and mem_req_o, inta_o, busy_o and done_o are low. The reset flags therefore have the interrupt-enable bit cleared.
- R2: On entry the sequencer makes three word writes, in this order: flags_i to address SP-2, then cs_i to SP-4, then ip_i to SP-6. SP is sp_i captured at the boundary, and each address is SP zero-extended to 20 bits with upper bits 0. On completion sp_o = SP-6.
- R3: After the pushes, the new IP is read from byte address type×4 and the new CS from type×4+2. On completion they appear on ip_o and cs_o.
- R4: On entry, flags_o equals the captured flags with TF (bit 8, mask 0100h) and IF (bit 9, mask 0200h) cleared. The unmodified flags are what gets stacked.
- R5: A software-interrupt strobe enters through the type on swi_type_i, and any value from 0 to 255 is accepted.
- R6: Fixed types are: divide 0, single step 1, non-maskable 2, breakpoint 3, overflow 4. When several sources are pending, the order from highest to lowest is divide, software, breakpoint, overflow, non-maskable, maskable, single step.
- R7: An overflow strobe gives type 4 only when OF (bit 11, mask 0800h) of flags_i is 1. With OF = 0 it does nothing, and a lower source may still be taken.
- R8: A rising edge on nmi_i is latched, and it is taken at a later boundary whatever the value of IF. A level held high is taken only once, and a new edge is needed for the next entry.
- R9: The maskable request is accepted only while IF = 1. It then gives two one-cycle inta_o pulses with one low cycle between them. The type is captured from ack_type_i during the second pulse.
- R10: With TF = 1 and no higher source pending, a boundary gives a type 1 entry.
- R11: A return command reads IP at SP, CS at SP+2 and flags at SP+4. On completion ip_o, cs_o and flags_o carry those words and sp_o = SP+6. A return at a boundary takes precedence over requests.
- R12: Every memory access holds mem_req_o, address, write enable and write data steady until a cycle with mem_ready_i high, and only then advances.
- R13: Sources are sampled only when boundary_i is high while the sequencer is idle, and a boundary during a sequence is ignored. done_o is a one-cycle pulse in the cycle after the last access completes, and busy_o is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction boundary; sources are sampled here |
| div_err_i | input | 1 | Divide fault strobe |
| swi_i | input | 1 | Software interrupt strobe |
| swi_type_i | input | 8 | Type for the software interrupt |
| into_i | input | 1 | Overflow check strobe |
| brk_i | input | 1 | Breakpoint strobe |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| intr_i | input | 1 | Maskable request, level |
| iret_i | input | 1 | Return command |
| flags_i | input | 16 | Current flags word |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Return instruction pointer |
| sp_i | input | 16 | Current stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 20 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes this cycle |
| inta_o | output | 1 | Interrupt acknowledge pulse |
| ack_type_i | input | 8 | Type byte from the acknowledging controller |
| flags_o | output | 16 | New flags |
| cs_o | output | 16 | New code segment |
| ip_o | output | 16 | New instruction pointer |
| sp_o | output | 16 | New stack pointer |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | A sequence is in progress |

## Verification
The checker watches, on every cycle, the memory-port hold rule while ready is low, the spacing of acknowledge pulses, the zero upper address bits of stack writes, the quiet port while idle and the form of the completion pulse. What the sequencer computes can be shown only by the bench's scenarios. That covers the order and addresses of the stacked words, the vector words chosen for every type, the cleared flag bits, the priority among simultaneous sources, the single-shot behaviour of the edge request, the masking of the level request and the restore on return.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int TF_BIT = 8;
  localparam int IF_BIT = 9;
  localparam int OF_BIT = 11;

  localparam int T_DIV  = 0;
  localparam int T_STEP = 1;
  localparam int T_NMI  = 2;
  localparam int T_BRK  = 3;
  localparam int T_OVF  = 4;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ACK1,
    S_ACKGAP,
    S_ACK2,
    S_PSH_F,
    S_PSH_CS,
    S_PSH_IP,
    S_RD_IP,
    S_RD_CS,
    S_POP_IP,
    S_POP_CS,
    S_POP_F
  } seq_state_e;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic take_i,
  output logic pend_o
);
  logic nmi_q, pend_q, pend_d, rise;

  assign rise   = nmi_i & ~nmi_q;
  assign pend_d = rise | (pend_q & ~take_i);
  assign pend_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int TW = 8
) (
  input  logic          div_err_i,
  input  logic          swi_i,
  input  logic [TW-1:0] swi_type_i,
  input  logic          brk_i,
  input  logic          into_i,
  input  logic          of_flag_i,
  input  logic          nmi_pend_i,
  input  logic          intr_i,
  input  logic          if_flag_i,
  input  logic          tf_flag_i,
  output logic          hit_o,
  output logic          need_ack_o,
  output logic          nmi_take_o,
  output logic [TW-1:0] type_o
);
  import irq_seq_pkg::*;

  always_comb begin
    hit_o      = 1'b1;
    need_ack_o = 1'b0;
    nmi_take_o = 1'b0;
    type_o     = '0;
    if (div_err_i) begin
      type_o = TW'(T_DIV);
    end else if (swi_i) begin
      type_o = swi_type_i;
    end else if (brk_i) begin
      type_o = TW'(T_BRK);
    end else if (into_i && of_flag_i) begin
      type_o = TW'(T_OVF);
    end else if (nmi_pend_i) begin
      type_o     = TW'(T_NMI);
      nmi_take_o = 1'b1;
    end else if (intr_i && if_flag_i) begin
      need_ack_o = 1'b1;
    end else if (tf_flag_i) begin
      type_o = TW'(T_STEP);
    end else begin
      hit_o = 1'b0;
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary_i,
  input  logic          div_err_i,
  input  logic          swi_i,
  input  logic [TW-1:0] swi_type_i,
  input  logic          into_i,
  input  logic          brk_i,
  input  logic          nmi_i,
  input  logic          intr_i,
  input  logic          iret_i,
  input  logic [DW-1:0] flags_i,
  input  logic [DW-1:0] cs_i,
  input  logic [DW-1:0] ip_i,
  input  logic [DW-1:0] sp_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          inta_o,
  input  logic [TW-1:0] ack_type_i,
  output logic [DW-1:0] flags_o,
  output logic [DW-1:0] cs_o,
  output logic [DW-1:0] ip_o,
  output logic [DW-1:0] sp_o,
  output logic          done_o,
  output logic          busy_o
);
  import irq_seq_pkg::*;

  localparam logic [DW-1:0] WSTEP   = DW'(2);
  localparam logic [DW-1:0] CLR_MSK = ~((DW'(1) << TF_BIT) | (DW'(1) << IF_BIT));
  localparam int            SPAD    = AW - DW;
  localparam int            VPAD    = AW - TW - 2;

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  seq_state_e    state_q, state_d;
  logic [DW-1:0] sp_q, fl_sv, cs_sv, ip_sv, tmp_ip, tmp_cs;
  logic [DW-1:0] flags_q, cs_q, ip_q, spo_q;
  logic [TW-1:0] type_q;
  logic          done_q;

  logic          arb_hit, arb_ack, arb_nmi, nmi_pend;
  logic [TW-1:0] arb_type;
  logic          idle, accept, st_push, st_pop, fire, fin_entry, fin_ret;

  assign idle   = (state_q == S_IDLE);
  assign accept = idle & boundary_i & (iret_i | arb_hit);

  irq_nmi_latch u_nmi (
    .clk    (clk),
    .rst_n  (rst_q),
    .nmi_i  (nmi_i),
    .take_i (idle & boundary_i & ~iret_i & arb_nmi),
    .pend_o (nmi_pend)
  );

  irq_arbiter #(.TW(TW)) u_arb (
    .div_err_i  (div_err_i),
    .swi_i      (swi_i),
    .swi_type_i (swi_type_i),
    .brk_i      (brk_i),
    .into_i     (into_i),
    .of_flag_i  (flags_i[OF_BIT]),
    .nmi_pend_i (nmi_pend),
    .intr_i     (intr_i),
    .if_flag_i  (flags_i[IF_BIT]),
    .tf_flag_i  (flags_i[TF_BIT]),
    .hit_o      (arb_hit),
    .need_ack_o (arb_ack),
    .nmi_take_o (arb_nmi),
    .type_o     (arb_type)
  );

  assign st_push   = (state_q == S_PSH_F) | (state_q == S_PSH_CS) | (state_q == S_PSH_IP);
  assign st_pop    = (state_q == S_POP_IP) | (state_q == S_POP_CS) | (state_q == S_POP_F);
  assign mem_req_o = st_push | st_pop | (state_q == S_RD_IP) | (state_q == S_RD_CS);
  assign mem_we_o  = st_push;
  assign fire      = mem_req_o & mem_ready_i;
  assign fin_entry = fire & (state_q == S_RD_CS);
  assign fin_ret   = fire & (state_q == S_POP_F);
  assign inta_o    = (state_q == S_ACK1) | (state_q == S_ACK2);

  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_PSH_F:  begin mem_addr_o = {{SPAD{1'b0}}, sp_q - WSTEP}; mem_wdata_o = fl_sv; end
      S_PSH_CS: begin mem_addr_o = {{SPAD{1'b0}}, sp_q - WSTEP}; mem_wdata_o = cs_sv; end
      S_PSH_IP: begin mem_addr_o = {{SPAD{1'b0}}, sp_q - WSTEP}; mem_wdata_o = ip_sv; end
      S_RD_IP:  mem_addr_o = {{VPAD{1'b0}}, type_q, 2'b00};
      S_RD_CS:  mem_addr_o = {{VPAD{1'b0}}, type_q, 2'b10};
      S_POP_IP, S_POP_CS, S_POP_F: mem_addr_o = {{SPAD{1'b0}}, sp_q};
      default:  ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (boundary_i) begin
          if (iret_i)       state_d = S_POP_IP;
          else if (arb_ack) state_d = S_ACK1;
          else if (arb_hit) state_d = S_PSH_F;
        end
      end
      S_ACK1:   state_d = S_ACKGAP;
      S_ACKGAP: state_d = S_ACK2;
      S_ACK2:   state_d = S_PSH_F;
      S_PSH_F:  if (mem_ready_i) state_d = S_PSH_CS;
      S_PSH_CS: if (mem_ready_i) state_d = S_PSH_IP;
      S_PSH_IP: if (mem_ready_i) state_d = S_RD_IP;
      S_RD_IP:  if (mem_ready_i) state_d = S_RD_CS;
      S_RD_CS:  if (mem_ready_i) state_d = S_IDLE;
      S_POP_IP: if (mem_ready_i) state_d = S_POP_CS;
      S_POP_CS: if (mem_ready_i) state_d = S_POP_F;
      S_POP_F:  if (mem_ready_i) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= S_IDLE;
      sp_q    <= '0;
      fl_sv   <= '0;
      cs_sv   <= '0;
      ip_sv   <= '0;
      tmp_ip  <= '0;
      tmp_cs  <= '0;
      type_q  <= '0;
      flags_q <= '0;
      cs_q    <= '0;
      ip_q    <= '0;
      spo_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_entry | fin_ret;
      if (accept) begin
        sp_q   <= sp_i;
        fl_sv  <= flags_i;
        cs_sv  <= cs_i;
        ip_sv  <= ip_i;
        type_q <= arb_type;
      end
      if (state_q == S_ACK2) type_q <= ack_type_i;
      if (fire && st_push) sp_q <= sp_q - WSTEP;
      if (fire && st_pop)  sp_q <= sp_q + WSTEP;
      if (fire && (state_q == S_RD_IP || state_q == S_POP_IP)) tmp_ip <= mem_rdata_i;
      if (fire && state_q == S_POP_CS) tmp_cs <= mem_rdata_i;
      if (fin_entry) begin
        ip_q    <= tmp_ip;
        cs_q    <= mem_rdata_i;
        flags_q <= fl_sv & CLR_MSK;
        spo_q   <= sp_q;
      end
      if (fin_ret) begin
        ip_q    <= tmp_ip;
        cs_q    <= tmp_cs;
        flags_q <= mem_rdata_i;
        spo_q   <= sp_q + WSTEP;
      end
    end
  end

  assign flags_o = flags_q;
  assign cs_o    = cs_q;
  assign ip_o    = ip_q;
  assign sp_o    = spo_q;
  assign done_o  = done_q;
  assign busy_o  = ~idle;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int DW = 16,
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          inta_o,
  input logic          busy_o,
  input logic          done_o
);
  // R12: access held steady until ready
  a_r12_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
                                  && $stable(mem_we_o) && $stable(mem_wdata_o));

  // R9: acknowledge pulses last one cycle, with a gap
  a_r9_ack_gap: assert property (@(posedge clk) disable iff (!rst_n)
    inta_o |=> !inta_o);

  // R2: stack writes stay in the zero-extended range
  a_r2_stack_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> mem_addr_o[AW-1:DW] == '0);

  // R13: completion pulse is seen with the sequencer idle
  a_r13_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R13: completion is a single-cycle pulse
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R13: no traffic while idle
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !inta_o);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .inta_o      (inta_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary_i = 0, div_err_i = 0, swi_i = 0, into_i = 0, brk_i = 0;
  logic        nmi_i = 0, intr_i = 0, iret_i = 0;
  logic [7:0]  swi_type_i = 0, ack_type_i = 0;
  logic [15:0] flags_i = 0, cs_i = 0, ip_i = 0, sp_i = 0;
  logic        mem_req_o, mem_we_o, mem_ready_i, inta_o, done_o, busy_o;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_wdata_o, mem_rdata_i, flags_o, cs_o, ip_o, sp_o;

  logic [15:0] bmem [0:2047];
  logic        wait_en = 1'b0;
  logic [1:0]  wcnt = 2'b00;
  int          inta_cnt = 0;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  irq_entry_seq u_dut (.*);

  assign mem_rdata_i = bmem[mem_addr_o[11:1]];
  assign mem_ready_i = wait_en ? (wcnt == 2'b11) : 1'b1;

  always @(posedge clk)
    if (mem_req_o && mem_we_o && mem_ready_i) bmem[mem_addr_o[11:1]] <= mem_wdata_o;

  always @(negedge clk) begin
    wcnt <= wcnt + 2'd1;
    if (inta_o) inta_cnt = inta_cnt + 1;
    cyc = cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [15:0] vip(int t); return {t[7:0], ~t[7:0]}; endfunction
  function automatic logic [15:0] vcs(int t); return 16'h8000 | 16'(t * 7); endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic bnd();
    inta_cnt = 0;
    boundary_i = 1'b1;
    @(negedge clk);
    boundary_i = 1'b0; div_err_i = 0; swi_i = 0; into_i = 0; brk_i = 0; iret_i = 0;
  endtask

  task automatic wait_done(string rq);
    bit seen = 0;
    for (int i = 0; i < 400; i++) begin
      if (done_o) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(rq, 32'(seen), 32'd1);
  endtask

  task automatic expect_none(string rq);
    bit act = 0;
    for (int i = 0; i < 12; i++) begin
      if (done_o || busy_o || inta_cnt != 0) act = 1;
      @(negedge clk);
    end
    chk(rq, 32'(act), 32'd0);
  endtask

  task automatic chk_vec(string rq, int t);
    chk(rq, 32'(ip_o), 32'(vip(t)));
    chk(rq, 32'(cs_o), 32'(vcs(t)));
  endtask

  initial begin
    for (int t = 0; t < 256; t++) begin
      bmem[t * 2]     = vip(t);
      bmem[t * 2 + 1] = vcs(t);
    end
    for (int a = 512; a < 2048; a++) bmem[a] = 16'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 flags", 32'(flags_o), 0); chk("R1 cs", 32'(cs_o), 0);
    chk("R1 ip", 32'(ip_o), 0);       chk("R1 sp", 32'(sp_o), 0);
    chk("R1 ctl", {28'h0, mem_req_o, inta_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", {28'h0, mem_req_o, inta_o, busy_o, done_o}, 0);

    // R5 R2 R3 R4 R12: all software types, alternating wait states
    for (int t = 0; t < 256; t++) begin
      logic [15:0] f, c, p, s;
      f = 16'h0300 | 16'(t); c = 16'hA000 + 16'(t); p = 16'h2000 + 16'(t * 3);
      s = 16'h0F00 - 16'(t * 2);
      wait_en = t[0];
      flags_i = f; cs_i = c; ip_i = p; sp_i = s; swi_i = 1; swi_type_i = 8'(t);
      bnd();
      wait_done("R5 done");
      wait_en = 0;
      chk_vec("R3/R5 vector", t);
      chk("R2 sp", 32'(sp_o), 32'(s - 16'd6));
      chk("R4 flags", 32'(flags_o), 32'(f & 16'hFCFF));
      chk("R2 push flags", 32'(bmem[(s - 16'd2) >> 1]), 32'(f));
      chk("R2 push cs", 32'(bmem[(s - 16'd4) >> 1]), 32'(c));
      chk("R2 push ip", 32'(bmem[(s - 16'd6) >> 1]), 32'(p));
    end

    // R11: return restores, with wait states
    flags_i = 16'h0B55; cs_i = 16'h1234; ip_i = 16'h4321; sp_i = 16'h0E00;
    brk_i = 1; wait_en = 1;
    bnd(); wait_done("R6 brk done"); chk_vec("R6 breakpoint type 3", 3);
    chk("R4 TF/IF cleared", 32'(flags_o), 32'h0855);
    sp_i = sp_o; flags_i = flags_o; cs_i = cs_o; ip_i = ip_o; iret_i = 1; swi_i = 1; swi_type_i = 8'h40;
    bnd(); wait_done("R11 done");
    chk("R11 ip", 32'(ip_o), 32'h4321); chk("R11 cs", 32'(cs_o), 32'h1234);
    chk("R11 flags", 32'(flags_o), 32'h0B55); chk("R11 sp", 32'(sp_o), 32'h0E00);
    wait_en = 0;

    // R6: priorities
    flags_i = 16'h0300; sp_i = 16'h0E00;
    nmi_i = 1; @(negedge clk);
    div_err_i = 1; swi_i = 1; swi_type_i = 8'h30; brk_i = 1; into_i = 1; intr_i = 1;
    bnd(); wait_done("R6 div"); chk_vec("R6 divide highest", 0);
    swi_i = 1; swi_type_i = 8'h30; brk_i = 1;
    bnd(); wait_done("R6 swi"); chk_vec("R6 software over breakpoint", 8'h30);
    flags_i = 16'h0B00; into_i = 1;
    bnd(); wait_done("R6 ovf"); chk_vec("R7 overflow type 4 over nmi", 4);
    flags_i = 16'h0300; ack_type_i = 8'h47;
    bnd(); wait_done("R6 nmi"); chk_vec("R6 nmi over maskable", 2);
    bnd(); wait_done("R9 intr"); chk_vec("R9 maskable type from ack", 8'h47);
    chk("R9 two ack pulses", 32'(inta_cnt), 2);
    intr_i = 0;

    // R8: held level is not retaken; new edge is taken with IF=0
    flags_i = 16'h0000;
    bnd(); expect_none("R8 held level ignored");
    nmi_i = 0; @(negedge clk); nmi_i = 1; @(negedge clk);
    bnd(); wait_done("R8 new edge"); chk_vec("R8 nmi with IF=0", 2);
    nmi_i = 0;

    // R9: maskable masked by IF=0
    intr_i = 1; flags_i = 16'h0000;
    bnd(); expect_none("R9 masked");
    intr_i = 0;

    // R7: overflow with OF=0
    into_i = 1; flags_i = 16'h0200;
    bnd(); expect_none("R7 OF=0 no-op");
    into_i = 1; flags_i = 16'h0100;
    bnd(); wait_done("R7 falls to step"); chk_vec("R7/R10 lower source taken", 1);

    // R10: trap flag, TF cleared in output
    flags_i = 16'h0381;
    bnd(); wait_done("R10 step"); chk_vec("R10 single-step type 1", 1);
    chk("R10 flags", 32'(flags_o), 32'h0081);

    // R13: no boundary means no sampling; boundary while busy ignored
    swi_i = 1; swi_type_i = 8'h11; @(negedge clk); @(negedge clk);
    chk("R13 no boundary", 32'(busy_o), 0);
    wait_en = 1; swi_type_i = 8'h21;
    bnd();
    swi_i = 1; swi_type_i = 8'h22; boundary_i = 1; @(negedge clk);
    boundary_i = 0; swi_i = 0;
    wait_done("R13 first done"); chk_vec("R13 busy boundary ignored", 8'h21);
    @(negedge clk); chk("R13 done pulse", 32'(done_o), 0);
    wait_en = 0;
    expect_none("R13 no second entry");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule